// File: doc/BRIEF.md
# System Clock Source Selector and Gater

This block derives the system clocks from four free-running oscillator inputs: a low-frequency crystal, a very-low-power internal oscillator, an optional high-frequency crystal and a digitally controlled oscillator (DCO). Control fields pick the source of each clock. The auxiliary clock comes from one of the two slow sources. The master clock can come from any of the four sources. The sub-main clock comes from one of the two fast sources. A divided copy of the auxiliary clock is produced for external use only. The master clock has its own power-of-two divider, and a gated copy of it drives the processor.

Every source change goes through a two-stage handshake. The old source is released on its own falling edge before the new source is admitted on its falling edge, so no output ever carries a shortened pulse. Three low-power bits taken from the processor status word drive the oscillator enable outputs and the processor clock gate. An oscillator may only be shut down once no master or sub-main path needs it, and no switch handshake is still holding it.

A fault input marks the high-frequency crystal as missing. While it is raised, and afterwards, the master clock is forced onto the DCO, and a sticky flag records the event until reset.

Top module: `sysclk_ctrl`

## Requirements
- R1: `auxSel` = 0 routes the low-frequency crystal to `auxClk`, and `auxSel` = 1 routes the very-low-power oscillator to it.
- R2: `auxExtClk` runs at the `auxClk` frequency divided by 2^`auxDiv` (code 0..3 gives /1, /2, /4, /8).
- R3: `mainSel` codes 0 (low-frequency crystal), 1 (very-low-power), 2 (high-frequency crystal) and 3 (DCO) select the master source, and `mainClk` runs at that source divided by 2^`mainDiv`.
- R4: `subSel` = 0 routes the high-frequency crystal to `subClk`, and `subSel` = 1 routes the DCO to it.
- R5: `dcoEn` is high while `scg1` is low. With `scg1` high, it stays high only while the DCO sources the master or sub-main clock, or a switch still holds it.
- R6: `lfEn` is high while `oscOff` is low. With `oscOff` high, it stays high only while the low-frequency crystal sources the master clock, or a master switch still holds it.
- R7: `hfEn` is high exactly while the high-frequency crystal is the effective master or sub-main source, or is held by a switch. `vloEn` is high exactly while the very-low-power oscillator is selected for the auxiliary or master clock, or is held by a switch.
- R8: `cpuClk` follows `mainClk` while `cpuOff` is low, and shows no rising edge while `cpuOff` is high. The gate changes only on a falling edge of `mainClk`.
- R9: Switching the source of `mainClk` (with divide code 0) or of `subClk` produces no high or low phase shorter than half the period of the faster source involved.
- R10: `hfFault` high forces the master clock onto the DCO whatever `mainSel` holds. It sets `faultFlag` at the next DCO rising edge, and `faultFlag` then stays high, keeping the DCO forced, until reset.
- R11: While `rstN` is low, all clock outputs and `faultFlag` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Active-low asynchronous reset |
| clkLf | input | 1 | Low-frequency crystal clock |
| clkVlo | input | 1 | Very-low-power internal clock |
| clkHf | input | 1 | High-frequency crystal clock |
| clkDco | input | 1 | Digitally controlled oscillator clock |
| auxSel | input | 1 | Auxiliary source: 0 low-frequency, 1 very-low-power |
| auxDiv | input | 2 | External auxiliary divide code (2^code) |
| mainSel | input | 2 | Master source code 0..3 |
| mainDiv | input | 2 | Master divide code (2^code) |
| subSel | input | 1 | Sub-main source: 0 high-frequency, 1 DCO |
| scg1 | input | 1 | Status bit requesting DCO shutdown |
| oscOff | input | 1 | Status bit requesting low-frequency crystal shutdown |
| cpuOff | input | 1 | Status bit gating the processor clock |
| hfFault | input | 1 | High-frequency crystal missing |
| auxClk | output | 1 | Auxiliary clock |
| auxExtClk | output | 1 | Divided auxiliary clock for external use |
| mainClk | output | 1 | Divided master clock |
| subClk | output | 1 | Sub-main clock |
| cpuClk | output | 1 | Gated master clock for the processor |
| lfEn | output | 1 | Low-frequency crystal enable |
| vloEn | output | 1 | Very-low-power oscillator enable |
| hfEn | output | 1 | High-frequency crystal enable |
| dcoEn | output | 1 | DCO enable |
| faultFlag | output | 1 | Sticky high-frequency fault flag |

## Verification
The oscillator enables are combinational in the selection and status bits, so the bench reads them 1 ns after changing an input once the handshakes have drained. The fault flag is due on the first DCO rising edge after `hfFault` rises, so it is read three bench cycles later. A new clock selection takes at most three edges of the old source plus three of the new one, and a divide change waits for the next counter wrap, which is under 500 ns with the slowest source. The bench therefore waits 1000 ns before it counts rising edges over a 2400 ns window, and it accepts a count within two of the count the requirement predicts. Phase widths are logged continuously while a switch is in progress.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {
    SRC_LF  = 2'd0,
    SRC_VLO = 2'd1,
    SRC_HF  = 2'd2,
    SRC_DCO = 2'd3
  } srcSel_e;

  localparam int NUM_SRC = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0]         mainSel;
    logic               auxSel;
    logic               subSel;
    logic               cpuRun;
    logic [NUM_SRC-1:0] oscEn;
  } pathCtl_t;

  // per-source hold status from datapath back to control
  typedef struct packed {
    logic [NUM_SRC-1:0] hold;
  } pathSts_t;
endpackage

// File: rtl/clk_switch.sv
module clk_switch #(
  parameter int N  = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          rstN,
  input  logic [N-1:0]  clkIn,
  input  logic [SW-1:0] sel,
  output logic          clkOut,
  output logic [N-1:0]  busy
);
  logic [N-1:0] en;

  for (genvar gi = 0; gi < N; gi++) begin : g_leg
    logic s1q, s2q, enq;
    logic othersBusy;
    logic req;

    assign othersBusy = |(busy & ~(N'(1) << gi));
    assign req        = (sel == SW'(gi)) && !othersBusy;

    always_ff @(posedge clkIn[gi] or negedge rstN) begin
      if (!rstN) begin
        s1q <= 1'b0;
        s2q <= 1'b0;
      end else begin
        s1q <= req;
        s2q <= s1q;
      end
    end

    // admit or release on the falling edge of the leg's own clock
    always_ff @(negedge clkIn[gi] or negedge rstN) begin
      if (!rstN) enq <= 1'b0;
      else       enq <= s2q;
    end

    assign en[gi]   = enq;
    assign busy[gi] = s1q | s2q | enq;
  end

  assign clkOut = |(clkIn & en);

  // R9
  always_comb begin
    if (rstN) begin
      switch_excl_chk: assert ($onehot0(busy))
        else $error("switch legs overlap");
    end
  end
endmodule

// File: rtl/clk_divider.sv
module clk_divider #(
  parameter int CW = 2,
  localparam int CNT_W = (1 << CW) - 1
) (
  input  logic          rstN,
  input  logic          clkIn,
  input  logic [CW-1:0] divCode,
  output logic          clkOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [CW-1:0]    codeQ;
  logic             wrap;
  logic [CNT_W:0]   taps;

  assign mask = (CNT_W'(1) << codeQ) - CNT_W'(1);
  assign wrap = (cnt & mask) == mask;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      codeQ <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (wrap) codeQ <= divCode;
    end
  end

  assign taps   = {cnt, clkIn};
  assign clkOut = taps[codeQ];
endmodule

// File: rtl/clk_ctrl.sv
module clk_ctrl
  import sysclk_pkg::*;
(
  input  logic       rstN,
  input  logic       clkDco,
  input  logic [1:0] mainSelIn,
  input  logic       auxSelIn,
  input  logic       subSelIn,
  input  logic       scg1,
  input  logic       oscOff,
  input  logic       cpuOff,
  input  logic       hfFault,
  input  pathSts_t   sts,
  output pathCtl_t   ctl,
  output logic       faultFlag
);
  logic               faultQ;
  logic               forceDco;
  srcSel_e            effMain;
  logic [NUM_SRC-1:0] useMain;
  logic [NUM_SRC-1:0] useSub;
  logic [NUM_SRC-1:0] oscEn;

  always_ff @(posedge clkDco or negedge rstN) begin
    if (!rstN)        faultQ <= 1'b0;
    else if (hfFault) faultQ <= 1'b1;
  end

  assign forceDco  = hfFault | faultQ;
  assign effMain   = forceDco ? SRC_DCO : srcSel_e'(mainSelIn);
  assign useMain   = NUM_SRC'(1) << effMain;
  assign useSub    = subSelIn ? (NUM_SRC'(1) << SRC_DCO) : (NUM_SRC'(1) << SRC_HF);
  assign faultFlag = faultQ;

  always_comb begin
    oscEn          = '0;
    oscEn[SRC_LF]  = !oscOff | useMain[SRC_LF] | sts.hold[SRC_LF];
    oscEn[SRC_VLO] = auxSelIn | useMain[SRC_VLO] | sts.hold[SRC_VLO];
    oscEn[SRC_HF]  = useMain[SRC_HF] | useSub[SRC_HF] | sts.hold[SRC_HF];
    oscEn[SRC_DCO] = !scg1 | useMain[SRC_DCO] | useSub[SRC_DCO] | sts.hold[SRC_DCO];
  end

  always_comb begin
    ctl.mainSel = effMain;
    ctl.auxSel  = auxSelIn;
    ctl.subSel  = subSelIn;
    ctl.cpuRun  = !cpuOff;
    ctl.oscEn   = oscEn;
  end

  // R10
  fault_sticky_chk: assert property (@(posedge clkDco) disable iff (!rstN)
    faultQ |=> faultQ) else $error("fault flag cleared");

  // R10
  fault_set_chk: assert property (@(posedge clkDco) disable iff (!rstN)
    hfFault |=> faultQ) else $error("fault flag not set");
endmodule

// File: rtl/clk_path.sv
module clk_path
  import sysclk_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             rstN,
  input  logic             clkLf,
  input  logic             clkVlo,
  input  logic             clkHf,
  input  logic             clkDco,
  input  pathCtl_t         ctl,
  input  logic [DIV_W-1:0] auxDiv,
  input  logic [DIV_W-1:0] mainDiv,
  output logic             auxClk,
  output logic             auxExtClk,
  output logic             mainClk,
  output logic             subClk,
  output logic             cpuClk,
  output pathSts_t         sts
);
  logic [NUM_SRC-1:0] mainBusy;
  logic [1:0]         auxBusy;
  logic [1:0]         subBusy;
  logic               mainRaw;
  logic               runQ;

  clk_switch #(.N(NUM_SRC)) u_mainSw (
    .rstN  (rstN),
    .clkIn ({clkDco, clkHf, clkVlo, clkLf}),
    .sel   (ctl.mainSel),
    .clkOut(mainRaw),
    .busy  (mainBusy)
  );

  clk_switch #(.N(2)) u_auxSw (
    .rstN  (rstN),
    .clkIn ({clkVlo, clkLf}),
    .sel   (ctl.auxSel),
    .clkOut(auxClk),
    .busy  (auxBusy)
  );

  clk_switch #(.N(2)) u_subSw (
    .rstN  (rstN),
    .clkIn ({clkDco, clkHf}),
    .sel   (ctl.subSel),
    .clkOut(subClk),
    .busy  (subBusy)
  );

  clk_divider #(.CW(DIV_W)) u_mainDiv (
    .rstN   (rstN),
    .clkIn  (mainRaw),
    .divCode(mainDiv),
    .clkOut (mainClk)
  );

  clk_divider #(.CW(DIV_W)) u_auxDiv (
    .rstN   (rstN),
    .clkIn  (auxClk),
    .divCode(auxDiv),
    .clkOut (auxExtClk)
  );

  // processor gate: enable changes only while mainClk is low
  always_ff @(negedge mainClk or negedge rstN) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= ctl.cpuRun;
  end
  assign cpuClk = mainClk & runQ;

  always_comb begin
    sts.hold          = mainBusy;
    sts.hold[SRC_VLO] = mainBusy[SRC_VLO] | auxBusy[1];
    sts.hold[SRC_HF]  = mainBusy[SRC_HF]  | subBusy[0];
    sts.hold[SRC_DCO] = mainBusy[SRC_DCO] | subBusy[1];
  end

  always_comb begin
    if (rstN) begin
      // R6
      lf_live_chk: assert (!mainBusy[SRC_LF] || ctl.oscEn[SRC_LF])
        else $error("LF stopped while held");
      // R7
      vlo_live_chk: assert (!sts.hold[SRC_VLO] || ctl.oscEn[SRC_VLO])
        else $error("VLO stopped while held");
      // R7
      hf_live_chk: assert (!sts.hold[SRC_HF] || ctl.oscEn[SRC_HF])
        else $error("HF stopped while held");
      // R5
      dco_live_chk: assert (!sts.hold[SRC_DCO] || ctl.oscEn[SRC_DCO])
        else $error("DCO stopped while held");
      // R1
      aux_excl_chk: assert (!(auxBusy[0] && auxBusy[1]))
        else $error("aux legs overlap");
    end
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             rstN,
  input  logic             clkLf,
  input  logic             clkVlo,
  input  logic             clkHf,
  input  logic             clkDco,
  input  logic             auxSel,
  input  logic [DIV_W-1:0] auxDiv,
  input  logic [1:0]       mainSel,
  input  logic [DIV_W-1:0] mainDiv,
  input  logic             subSel,
  input  logic             scg1,
  input  logic             oscOff,
  input  logic             cpuOff,
  input  logic             hfFault,
  output logic             auxClk,
  output logic             auxExtClk,
  output logic             mainClk,
  output logic             subClk,
  output logic             cpuClk,
  output logic             lfEn,
  output logic             vloEn,
  output logic             hfEn,
  output logic             dcoEn,
  output logic             faultFlag
);
  pathCtl_t ctl;
  pathSts_t sts;

  clk_ctrl u_ctrl (
    .rstN     (rstN),
    .clkDco   (clkDco),
    .mainSelIn(mainSel),
    .auxSelIn (auxSel),
    .subSelIn (subSel),
    .scg1     (scg1),
    .oscOff   (oscOff),
    .cpuOff   (cpuOff),
    .hfFault  (hfFault),
    .sts      (sts),
    .ctl      (ctl),
    .faultFlag(faultFlag)
  );

  clk_path #(.DIV_W(DIV_W)) u_path (
    .rstN     (rstN),
    .clkLf    (clkLf),
    .clkVlo   (clkVlo),
    .clkHf    (clkHf),
    .clkDco   (clkDco),
    .ctl      (ctl),
    .auxDiv   (auxDiv),
    .mainDiv  (mainDiv),
    .auxClk   (auxClk),
    .auxExtClk(auxExtClk),
    .mainClk  (mainClk),
    .subClk   (subClk),
    .cpuClk   (cpuClk),
    .sts      (sts)
  );

  assign lfEn  = ctl.oscEn[SRC_LF];
  assign vloEn = ctl.oscEn[SRC_VLO];
  assign hfEn  = ctl.oscEn[SRC_HF];
  assign dcoEn = ctl.oscEn[SRC_DCO];
endmodule

// File: tb/sysclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysclk_ctrl_tb_top;
  localparam real PER_LF  = 40.0;
  localparam real PER_VLO = 56.0;
  localparam real PER_HF  = 12.0;
  localparam real PER_DCO = 4.0;
  localparam real WIN     = 2400.0;

  logic clk = 1'b0, clkLf = 1'b0, clkVlo = 1'b0, clkHf = 1'b0;
  logic rstN = 1'b0;
  logic auxSel = 1'b0, subSel = 1'b1;
  logic [1:0] auxDiv = 2'd0, mainSel = 2'd3, mainDiv = 2'd0;
  logic scg1 = 1'b0, oscOff = 1'b0, cpuOff = 1'b0, hfFault = 1'b0;
  logic auxClk, auxExtClk, mainClk, subClk, cpuClk;
  logic lfEn, vloEn, hfEn, dcoEn, faultFlag;

  int nChk = 0, nFail = 0;
  int nAux = 0, nExt = 0, nMain = 0, nSub = 0, nCpu = 0;
  int dAux, dExt, dMain, dSub, dCpu;
  realtime lastM = 0.0, lastS = 0.0, minM = 1000.0, minS = 1000.0;
  int armM = 0, armS = 0;

  always #2  clk    = ~clk;
  always #20 clkLf  = ~clkLf;
  always #28 clkVlo = ~clkVlo;
  always #6  clkHf  = ~clkHf;

  sysclk_ctrl dut_i (
    .rstN(rstN), .clkLf(clkLf), .clkVlo(clkVlo), .clkHf(clkHf), .clkDco(clk),
    .auxSel(auxSel), .auxDiv(auxDiv), .mainSel(mainSel), .mainDiv(mainDiv),
    .subSel(subSel), .scg1(scg1), .oscOff(oscOff), .cpuOff(cpuOff),
    .hfFault(hfFault), .auxClk(auxClk), .auxExtClk(auxExtClk),
    .mainClk(mainClk), .subClk(subClk), .cpuClk(cpuClk), .lfEn(lfEn),
    .vloEn(vloEn), .hfEn(hfEn), .dcoEn(dcoEn), .faultFlag(faultFlag)
  );

  always @(posedge auxClk)    nAux++;
  always @(posedge auxExtClk) nExt++;
  always @(posedge mainClk)   nMain++;
  always @(posedge subClk)    nSub++;
  always @(posedge cpuClk)    nCpu++;

  always @(mainClk) begin
    if (armM == 2 && ($realtime - lastM) < minM) minM = $realtime - lastM;
    lastM = $realtime;
    if (armM == 1) armM = 2;
  end
  always @(subClk) begin
    if (armS == 2 && ($realtime - lastS) < minS) minS = $realtime - lastS;
    lastS = $realtime;
    if (armS == 1) armS = 2;
  end

  function automatic int expE(real per);
    return $rtoi(WIN / per + 0.5);
  endfunction

  task automatic same(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic near(string req, string what, int act, int exp);
    nChk++;
    if (act > exp + 2 || act < exp - 2) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    #1000;
    @(posedge clk);
    #1;
  endtask

  task automatic measure();
    int a0, e0, m0, s0, c0;
    a0 = nAux; e0 = nExt; m0 = nMain; s0 = nSub; c0 = nCpu;
    #(WIN);
    dAux = nAux - a0; dExt = nExt - e0; dMain = nMain - m0;
    dSub = nSub - s0; dCpu = nCpu - c0;
  endtask

  task automatic testReset();
    int hot;
    hot = 0;
    for (int k = 0; k < 12; k++) begin
      #7;
      hot += int'(auxClk) + int'(auxExtClk) + int'(mainClk) + int'(subClk)
           + int'(cpuClk) + int'(faultFlag);
    end
    same("R11", "outputs high during reset", hot, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  task automatic testAux();
    auxSel = 1'b0; auxDiv = 2'd0; settle(); measure();
    near("R1", "aux on LF", dAux, expE(PER_LF));
    near("R2", "ext /1", dExt, expE(PER_LF));
    auxSel = 1'b1; auxDiv = 2'd2; settle(); measure();
    near("R1", "aux on VLO", dAux, expE(PER_VLO));
    near("R2", "ext /4 of VLO", dExt, expE(PER_VLO * 4.0));
    auxSel = 1'b0; auxDiv = 2'd3; settle(); measure();
    near("R2", "ext /8 of LF", dExt, expE(PER_LF * 8.0));
  endtask

  task automatic testMain();
    mainSel = 2'd0; mainDiv = 2'd1; settle(); measure();
    near("R3", "main LF /2", dMain, expE(PER_LF * 2.0));
    mainSel = 2'd1; mainDiv = 2'd0; settle(); measure();
    near("R3", "main VLO /1", dMain, expE(PER_VLO));
    mainSel = 2'd2; mainDiv = 2'd3; settle(); measure();
    near("R3", "main HF /8", dMain, expE(PER_HF * 8.0));
    mainSel = 2'd3; mainDiv = 2'd2; settle(); measure();
    near("R3", "main DCO /4", dMain, expE(PER_DCO * 4.0));
    near("R8", "cpu follows main", dCpu, dMain);
  endtask

  task automatic testGlitch();
    mainDiv = 2'd0; subSel = 1'b1; settle();
    minM = 1000.0; minS = 1000.0; armM = 1; armS = 1;
    mainSel = 2'd0; settle();
    mainSel = 2'd2; settle();
    mainSel = 2'd1; settle();
    mainSel = 2'd3; settle();
    subSel = 1'b0; settle();
    measure();
    near("R4", "sub on HF", dSub, expE(PER_HF));
    subSel = 1'b1; settle();
    measure();
    near("R4", "sub on DCO", dSub, expE(PER_DCO));
    armM = 0; armS = 0;
    nChk++;
    if (minM < 1.9) begin
      nFail++;
      $display("FAIL R9 main phase: got %0d ps expected >= 1900 ps", $rtoi(minM * 1000.0));
    end
    nChk++;
    if (minS < 1.9) begin
      nFail++;
      $display("FAIL R9 sub phase: got %0d ps expected >= 1900 ps", $rtoi(minS * 1000.0));
    end
  endtask

  task automatic testOscEn();
    scg1 = 1'b1; mainSel = 2'd0; subSel = 1'b0; settle();
    same("R5", "dcoEn with DCO unused", int'(dcoEn), 0);
    subSel = 1'b1; #1;
    same("R5", "dcoEn with sub on DCO", int'(dcoEn), 1);
    settle();
    scg1 = 1'b0; subSel = 1'b0; settle();
    same("R5", "dcoEn with scg1 low", int'(dcoEn), 1);
    oscOff = 1'b1; #1;
    same("R6", "lfEn with main on LF", int'(lfEn), 1);
    mainSel = 2'd3; settle();
    same("R6", "lfEn with LF unused", int'(lfEn), 0);
    oscOff = 1'b0; #1;
    same("R6", "lfEn with oscOff low", int'(lfEn), 1);
    subSel = 1'b1; auxSel = 1'b0; settle();
    same("R7", "hfEn unused", int'(hfEn), 0);
    same("R7", "vloEn unused", int'(vloEn), 0);
    subSel = 1'b0; auxSel = 1'b1; #1;
    same("R7", "hfEn with sub on HF", int'(hfEn), 1);
    same("R7", "vloEn with aux on VLO", int'(vloEn), 1);
    subSel = 1'b1; auxSel = 1'b0; settle();
  endtask

  task automatic testCpu();
    mainSel = 2'd3; mainDiv = 2'd0; cpuOff = 1'b1; settle(); measure();
    same("R8", "cpu edges while off", dCpu, 0);
    near("R8", "main runs while cpu off", dMain, expE(PER_DCO));
    cpuOff = 1'b0; settle(); measure();
    near("R8", "cpu edges while on", dCpu, dMain);
  endtask

  task automatic testFault();
    mainSel = 2'd2; mainDiv = 2'd0; settle(); measure();
    near("R3", "main on HF", dMain, expE(PER_HF));
    same("R10", "flag before fault", int'(faultFlag), 0);
    hfFault = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    same("R10", "flag after fault", int'(faultFlag), 1);
    settle(); measure();
    near("R10", "main forced to DCO", dMain, expE(PER_DCO));
    hfFault = 1'b0; settle(); measure();
    near("R10", "main stays on DCO", dMain, expE(PER_DCO));
    same("R10", "flag sticky", int'(faultFlag), 1);
    rstN = 1'b0; #20;
    same("R10", "flag cleared by reset", int'(faultFlag), 0);
    same("R11", "main low in reset", int'(mainClk), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  initial begin
    #400000;
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    testReset();
    testAux();
    testMain();
    testGlitch();
    testOscEn();
    testCpu();
    testFault();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule